// File: doc/BRIEF.md
# Byte-Buffered NRZ Data Transmitter

This block turns a sequence of host-written bytes into a continuous non-return-to-zero serial stream at a low, programmable baud rate. A single holding register sits in front of an 8-bit shift register. While one byte is being shifted out, the host may place the next byte in the holding register. Each time a byte moves from the holding register into the shifter, the block raises a buffer-ready flag. If the host has not supplied a byte by the time the last bit of the current byte starts, the stream stops at the end of that byte, the line returns to idle, and a completion flag is raised.

Each bit lasts `PRESCALE * Q` clock cycles. A fixed prescaler feeds a counter that reloads from the programmed divisor `Q` at every bit boundary. For every bit, the block also produces an emphasis marker and a one-cycle strobe, and it holds a small gain register whose code and emphasis-enable bit drive a downstream level-adjust stage. When the encoder is disabled (power-save), the block returns to an off state.

The controller has three states. `ST_OFF` is entered on reset or whenever `enable` is low. `ST_OFF -> ST_IDLE` happens when `enable` is high. `ST_IDLE -> ST_SEND` (load) happens when the holding register is full. `ST_SEND` stays in place and shifts on each bit tick. At the end of the last bit, `ST_SEND` either reloads from the holding register and stays in `ST_SEND`, or returns to `ST_IDLE` (underrun end). `ST_IDLE` or `ST_SEND` goes to `ST_OFF` when `enable` falls.

Top module: `nrz_byte_tx`

## Requirements
- R1: After reset, `tx_idle`=1 and `tx_bit`, `bit_strobe`, `emph_bit`, `buf_ready`, `tx_done`, `gain_code`, `emph_en` are all 0.
- R2: While sending, each bit lasts exactly `PRESCALE*max(Q,1)` clock cycles; a `Q` of 0 behaves as 1.
- R3: Bits leave most significant first (bit 7 of the written byte) and are not inverted. The first byte written while enabled and idle appears on `tx_bit`, with `bit_strobe`=1, in the second cycle after the write edge. `tx_bit` and `emph_bit` are 0 while `tx_idle`=1, and `tx_bit` changes only on a strobe or with `tx_idle`=1.
- R4: `buf_ready` becomes 1 in the cycle a byte is moved into the shifter, unless a data write happens in that same cycle. Any accepted data write clears it on the next edge.
- R5: A byte that is in the holding register when the last bit of the current byte starts follows without a gap: its first bit starts exactly one bit period after that last bit.
- R6: If the holding register is empty when the last bit of a byte starts, then one bit period after that start `tx_idle`=1 and `tx_done`=1. An accepted data write clears `tx_done`.
- R7: A write while the holding register is full replaces the pending byte, and the byte being shifted is sent unchanged.
- R8: `emph_bit` is 1 for a bit exactly when `emph_en` is 1 and the next bit of the stream differs. For the last bit of a byte, the next bit is bit 7 of the byte pending at that bit's start; with no pending byte the flag is 0.
- R9: A gain write stores `gain_in`. Bits 2..0 drive `gain_code` and bit 3 drives `emph_en`, both on the next edge.
- R10: With `enable`=0, data writes are ignored, the holding register is emptied, `buf_ready` and `tx_done` clear, and the line goes idle on the next edge. Nothing is sent after re-enabling until a new byte is written.
- R11: A change to `q_value` during a bit leaves that bit's length unchanged and applies from the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Encoder enable; low is power-save |
| q_value | input | QW | Baud divisor Q |
| data_wr | input | 1 | Data byte write strobe |
| data_in | input | DW | Data byte to send |
| gain_wr | input | 1 | Gain register write strobe |
| gain_in | input | 4 | Gain register value: [3] emphasis enable, [2:0] level code |
| tx_bit | output | 1 | Serial data bit |
| tx_idle | output | 1 | Line idle (mid-level) indicator |
| bit_strobe | output | 1 | One-cycle pulse at the start of each bit |
| emph_bit | output | 1 | Current bit needs extra gain |
| buf_ready | output | 1 | Holding register can take another byte |
| tx_done | output | 1 | Stream ended on underrun |
| gain_code | output | 3 | Level code for the downstream stage |
| emph_en | output | 1 | Emphasis enable from the gain register |

## Verification
A data write taken at one edge shows up on the line two edges later. After that, each new bit comes exactly `PRESCALE*Q` cycles after the previous strobe. The idle state and `tx_done` arrive one bit period after the strobe of a last bit that found the buffer empty. Flag changes and gain outputs are due one edge after their cause. The bench drives inputs and samples outputs on falling edges. It counts falling edges from one strobe to the next, including the ones spent on writes, and compares each count with the arithmetic period. It samples end-of-stream state exactly `period-1` and `period` edges after the last strobe.

// File: rtl/nrz_tx_pkg.sv
`timescale 1ns/1ps
package nrz_tx_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_SEND = 2'd2
    } tx_state_e;
endpackage

// File: rtl/nrz_baud_gen.sv
`timescale 1ns/1ps
// Bit timing: fixed prescaler followed by a counter reloaded from Q at each bit boundary.
module nrz_baud_gen #(
    parameter int PRESCALE = 32,
    parameter int QW       = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [QW-1:0] q,
    output logic          bit_tick
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;

    logic [PW-1:0] pre_cnt;
    logic [QW-1:0] baud_cnt;
    logic [QW-1:0] q_lat;
    logic [QW-1:0] q_eff;
    logic          pre_tick;

    assign q_eff    = (q == '0) ? QW'(1) : q;
    assign pre_tick = run && (pre_cnt == PW'(PRESCALE - 1));
    assign bit_tick = pre_tick && (baud_cnt >= (q_lat - QW'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            baud_cnt <= '0;
            q_lat    <= QW'(1);
        end else if (!run) begin
            pre_cnt  <= '0;
            baud_cnt <= '0;
            q_lat    <= q_eff;
        end else begin
            pre_cnt <= pre_tick ? '0 : pre_cnt + PW'(1);
            if (bit_tick) begin
                baud_cnt <= '0;
                q_lat    <= q_eff;
            end else if (pre_tick) begin
                baud_cnt <= baud_cnt + QW'(1);
            end
        end
    end
endmodule

// File: rtl/nrz_hold_buf.sv
`timescale 1ns/1ps
// Single-entry holding register in front of the shifter.
module nrz_hold_buf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (!enable) begin
            full <= 1'b0;
        end else if (wr_en) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/nrz_shift_fsm.sv
`timescale 1ns/1ps
// Controller, shift register, emphasis marker and event flags.
module nrz_shift_fsm
    import nrz_tx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          bit_tick,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    input  logic          wr_en,
    input  logic          pe_en,
    output logic          take,
    output logic          run,
    output logic          tx_bit,
    output logic          tx_idle,
    output logic          bit_strobe,
    output logic          emph_bit,
    output logic          buf_ready,
    output logic          tx_done
);
    localparam int IW = $clog2(DW);

    tx_state_e     state_q, state_d;
    logic [DW-1:0] shreg;
    logic [IW-1:0] bit_idx;
    logic          final_q;
    logic          emph_q;
    logic          do_load, do_shift, do_end;
    logic          last_bit;

    assign last_bit = (bit_idx == IW'(DW - 1));

    always_comb begin
        state_d  = state_q;
        do_load  = 1'b0;
        do_shift = 1'b0;
        do_end   = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (enable) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!enable) begin
                    state_d = ST_OFF;
                end else if (hold_full) begin
                    do_load = 1'b1;
                    state_d = ST_SEND;
                end
            end
            ST_SEND: begin
                if (!enable) begin
                    state_d = ST_OFF;
                end else if (bit_tick) begin
                    if (!last_bit) begin
                        do_shift = 1'b1;
                    end else if (final_q) begin
                        do_end  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        do_load = 1'b1;
                    end
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_idx    <= '0;
            final_q    <= 1'b0;
            emph_q     <= 1'b0;
            bit_strobe <= 1'b0;
            buf_ready  <= 1'b0;
            tx_done    <= 1'b0;
        end else begin
            bit_strobe <= do_load || do_shift;
            if (do_load) begin
                shreg   <= hold_data;
                bit_idx <= '0;
                final_q <= 1'b0;
                emph_q  <= pe_en && (hold_data[DW-1] != hold_data[DW-2]);
            end else if (do_shift) begin
                shreg   <= shreg << 1;
                bit_idx <= bit_idx + IW'(1);
                if (bit_idx == IW'(DW - 2)) begin
                    // deadline: the last bit starts now
                    final_q <= !hold_full;
                    emph_q  <= pe_en && hold_full && (shreg[DW-2] != hold_data[DW-1]);
                end else begin
                    emph_q  <= pe_en && (shreg[DW-2] != shreg[DW-3]);
                end
            end
            if (!enable) begin
                buf_ready <= 1'b0;
                tx_done   <= 1'b0;
            end else if (wr_en) begin
                buf_ready <= 1'b0;
                tx_done   <= 1'b0;
            end else begin
                if (do_load) buf_ready <= 1'b1;
                if (do_end)  tx_done   <= 1'b1;
            end
        end
    end

    assign take     = do_load;
    assign run      = (state_q == ST_SEND);
    assign tx_idle  = !run;
    assign tx_bit   = run && shreg[DW-1];
    assign emph_bit = run && emph_q;
endmodule

// File: rtl/nrz_byte_tx.sv
`timescale 1ns/1ps
module nrz_byte_tx #(
    parameter int PRESCALE = 32,
    parameter int QW       = 11,
    parameter int DW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [QW-1:0] q_value,
    input  logic          data_wr,
    input  logic [DW-1:0] data_in,
    input  logic          gain_wr,
    input  logic [3:0]    gain_in,
    output logic          tx_bit,
    output logic          tx_idle,
    output logic          bit_strobe,
    output logic          emph_bit,
    output logic          buf_ready,
    output logic          tx_done,
    output logic [2:0]    gain_code,
    output logic          emph_en
);
    logic          wr_ok;
    logic          take;
    logic          run;
    logic          bit_tick;
    logic          hold_full;
    logic [DW-1:0] hold_data;
    logic [3:0]    gain_q;

    assign wr_ok = data_wr && enable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       gain_q <= '0;
        else if (gain_wr) gain_q <= gain_in;
    end

    assign gain_code = gain_q[2:0];
    assign emph_en   = gain_q[3];

    nrz_baud_gen #(.PRESCALE(PRESCALE), .QW(QW)) baud_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .q        (q_value),
        .bit_tick (bit_tick)
    );

    nrz_hold_buf #(.DW(DW)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .wr_en   (wr_ok),
        .wr_data (data_in),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    nrz_shift_fsm #(.DW(DW)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .bit_tick   (bit_tick),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .wr_en      (wr_ok),
        .pe_en      (gain_q[3]),
        .take       (take),
        .run        (run),
        .tx_bit     (tx_bit),
        .tx_idle    (tx_idle),
        .bit_strobe (bit_strobe),
        .emph_bit   (emph_bit),
        .buf_ready  (buf_ready),
        .tx_done    (tx_done)
    );
endmodule

// File: rtl/nrz_byte_tx_chk.sv
`timescale 1ns/1ps
module nrz_byte_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       data_wr,
    input logic       gain_wr,
    input logic [3:0] gain_in,
    input logic       tx_bit,
    input logic       tx_idle,
    input logic       bit_strobe,
    input logic       emph_bit,
    input logic       buf_ready,
    input logic       tx_done,
    input logic [2:0] gain_code,
    input logic       emph_en
);
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> (!tx_bit && !emph_bit && !bit_strobe));

    assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_bit) |-> (bit_strobe || tx_idle));

    assert_strobe_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |=> !bit_strobe);

    assert_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && enable) |=> (!buf_ready && !tx_done));

    assert_start_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_idle) && !$past(data_wr && enable)) |-> buf_ready);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> tx_idle);

    assert_off_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!buf_ready && !tx_done && tx_idle));

    assert_gain_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gain_wr |=> ({emph_en, gain_code} == $past(gain_in)));
endmodule

bind nrz_byte_tx nrz_byte_tx_chk chk_i (.*);

// File: tb/nrz_byte_tx_tb_top.sv
`timescale 1ns/1ps
module nrz_byte_tx_tb_top;
    localparam int PS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [10:0] q_value = 11'd1;
    logic        data_wr = 1'b0;
    logic [7:0]  data_in = '0;
    logic        gain_wr = 1'b0;
    logic [3:0]  gain_in = '0;
    logic        tx_bit, tx_idle, bit_strobe, emph_bit, buf_ready, tx_done, emph_en;
    logic [2:0]  gain_code;

    int checks = 0;
    int errors = 0;
    int gap = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    nrz_byte_tx #(.PRESCALE(PS), .QW(11), .DW(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .q_value(q_value),
        .data_wr(data_wr), .data_in(data_in), .gain_wr(gain_wr), .gain_in(gain_in),
        .tx_bit(tx_bit), .tx_idle(tx_idle), .bit_strobe(bit_strobe), .emph_bit(emph_bit),
        .buf_ready(buf_ready), .tx_done(tx_done), .gain_code(gain_code), .emph_en(emph_en)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic data_write(logic [7:0] b);
        data_in = b;
        data_wr = 1'b1;
        @(negedge clk);
        gap++;
        data_wr = 1'b0;
    endtask

    task automatic gain_write(logic [3:0] g);
        gain_in = g;
        gain_wr = 1'b1;
        @(negedge clk);
        gap++;
        gain_wr = 1'b0;
    endtask

    task automatic wait_strobe();
        do begin
            @(negedge clk);
            gap++;
        end while (!bit_strobe && gap < 3000);
    endtask

    // Three-byte stream; the next byte is written at the strobe of bit wpos.
    task automatic run_stream(int q, bit pe, int wpos);
        logic [7:0] bs [3];
        int per;
        bit exp_e;
        per = PS * ((q == 0) ? 1 : q);
        for (int k = 0; k < 3; k++) bs[k] = 8'(q * 53 + int'(pe) * 29 + wpos * 11 + k * 77 + 'h35);
        q_value = 11'(q);
        gain_write({pe, 3'(q + 2)});
        chk("R9", "gain_code", int'(gain_code), (q + 2) % 8);
        chk("R9", "emph_en", int'(emph_en), int'(pe));
        data_write(bs[0]);
        chk("R6", "done cleared by write", int'(tx_done), 0);
        chk("R3", "no strobe one cycle after write", int'(bit_strobe), 0);
        @(negedge clk);
        chk("R3", "strobe two cycles after write", int'(bit_strobe), 1);
        gap = 0;
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 8; i++) begin
                if (!(k == 0 && i == 0)) begin
                    wait_strobe();
                    chk((i == 0) ? "R5" : "R2", "bit period", gap, per);
                    gap = 0;
                end
                chk("R3", "tx_bit", int'(tx_bit), int'(bs[k][7-i]));
                if (i < 7) exp_e = pe && (bs[k][7-i] != bs[k][6-i]);
                else       exp_e = pe && (k < 2) && (bs[k][0] != bs[(k < 2) ? k + 1 : k][7]);
                chk("R8", "emph_bit", int'(emph_bit), int'(exp_e));
                if (i == 0) chk("R4", "ready on load", int'(buf_ready), 1);
                if (i == wpos && k < 2) begin
                    data_write(bs[k+1]);
                    chk("R4", "ready cleared by write", int'(buf_ready), 0);
                end
            end
        end
        repeat (per - 1) @(negedge clk);
        chk("R6", "still sending before end", int'(tx_idle), 0);
        @(negedge clk);
        chk("R6", "idle after last bit", int'(tx_idle), 1);
        chk("R6", "done after underrun", int'(tx_done), 1);
        gap = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "tx_idle", int'(tx_idle), 1);
        chk("R1", "tx_bit", int'(tx_bit), 0);
        chk("R1", "strobe", int'(bit_strobe), 0);
        chk("R1", "emph_bit", int'(emph_bit), 0);
        chk("R1", "buf_ready", int'(buf_ready), 0);
        chk("R1", "tx_done", int'(tx_done), 0);
        chk("R1", "gain_code", int'(gain_code), 0);
        chk("R1", "emph_en", int'(emph_en), 0);

        // R10: write while disabled is dropped
        data_write(8'hA5);
        repeat (5) @(negedge clk);
        enable = 1'b1;
        begin
            int seen = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (bit_strobe || !tx_idle) seen++;
            end
            chk("R10", "disabled write sent", seen, 0);
        end

        // R2 R3 R4 R5 R6 R8 R9 sweep
        for (int qi = 0; qi < 4; qi++)
            for (int p = 0; p < 2; p++)
                for (int w = 0; w < 2; w++)
                    run_stream((qi == 3) ? 5 : qi, p[0], (w == 0) ? 0 : 6);

        // R10: disabling clears both flags
        chk("R10", "ready before off", int'(buf_ready), 1);
        chk("R10", "done before off", int'(tx_done), 1);
        enable = 1'b0;
        @(negedge clk);
        chk("R10", "ready after off", int'(buf_ready), 0);
        chk("R10", "done after off", int'(tx_done), 0);
        enable = 1'b1;
        @(negedge clk);

        // R7: overwrite of pending byte
        q_value = 11'd1;
        gain_write(4'h0);
        data_write(8'h3C);
        @(negedge clk);
        gap = 0;
        chk("R7", "bit 0 of first byte", int'(tx_bit), 0);
        data_write(8'hFF);
        wait_strobe();
        gap = 0;
        chk("R7", "bit 1 of first byte", int'(tx_bit), 0);
        data_write(8'h81);
        for (int i = 2; i < 8; i++) begin
            wait_strobe();
            chk("R7", "period", gap, PS);
            gap = 0;
            chk("R7", "first byte intact", int'(tx_bit), int'(((8'h3C) >> (7 - i)) & 1));
        end
        for (int i = 0; i < 8; i++) begin
            wait_strobe();
            gap = 0;
            chk("R7", "replacing byte sent", int'(tx_bit), int'(((8'h81) >> (7 - i)) & 1));
        end
        repeat (PS) @(negedge clk);
        chk("R7", "stream ends after two bytes", int'(tx_idle), 1);

        // R11: divisor change mid-bit
        q_value = 11'd2;
        data_write(8'hF0);
        @(negedge clk);
        gap = 0;
        q_value = 11'd5;
        wait_strobe();
        chk("R11", "current bit keeps old Q", gap, PS * 2);
        gap = 0;
        wait_strobe();
        chk("R11", "next bit uses new Q", gap, PS * 5);
        gap = 0;
        begin
            int c = 0;
            while (!tx_idle && c < 2000) begin
                @(negedge clk);
                c++;
            end
        end

        // R10: power-save mid-stream discards the pending byte
        q_value = 11'd1;
        data_write(8'hAA);
        wait_strobe();
        gap = 0;
        data_write(8'h55);
        wait_strobe();
        gap = 0;
        enable = 1'b0;
        @(negedge clk);
        chk("R10", "idle after off", int'(tx_idle), 1);
        chk("R10", "ready after off mid-stream", int'(buf_ready), 0);
        enable = 1'b1;
        begin
            int seen = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (bit_strobe || !tx_idle) seen++;
            end
            chk("R10", "pending byte dropped", seen, 0);
        end

        ended = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule